// File: doc/BRIEF.md
# Descriptor Ring Channel for a Block Cipher Engine (ECB)

This block is one channel of a descriptor-driven DMA engine that feeds a block cipher core running in electronic-codebook mode. It reads a ring of two-word buffer descriptors from a synchronous memory and checks whether each one is marked full. It then streams the referenced buffer either to the cipher's key loader or to its data input. ECB needs no initialization vector, so a job is simply a key descriptor followed by one or more data descriptors. The key must be loaded before the first data block is sent.

Each descriptor occupies two consecutive words at the fetch pointer. Word 0 holds the buffer's word address. Word 1 is the control word:

- bit 31: full flag
- bit 30: wrap flag
- bit 29: type (1 = key, 0 = data)
- bits 15:0: byte length

When the channel fetches a descriptor whose full flag is clear, it stops without touching the buffer and waits. Software then fills the descriptor, sets the flag and writes the channel-enable strobe to resume. Once a buffer has been fully consumed, the channel writes the control word back with the full flag cleared, so that software can refill that slot.

The memory port has one cycle of read latency and holds its read data while no request is made. The cipher side uses valid/ready handshakes on a shared 32-bit word bus.

Top module: `crdma_chan`

## Requirements
- R1: After reset the channel is idle. `chan_active`, `err_len`, `err_order`, `mem_req`, `key_valid` and `dat_valid` are all 0, and the fetch pointer equals `ring_base`, so the first descriptor read after enabling is at `ring_base`.
- R2: A one-cycle `ce_wr` pulse while idle starts descriptor fetching at the current pointer. `chan_active` reads 1 while the channel works and 0 once it has parked, and no memory request is made while it reads 0.
- R3: A descriptor whose full flag (bit 31 of word 1) is clear causes no buffer transfer and no write-back. The channel parks with the pointer still on that descriptor, so the next enable fetches it again.
- R4: A key descriptor (bit 29 = 1) sends length/4 buffer words, in address order, on the key handshake. `key_last` is high only with the final word.
- R5: A data descriptor (bit 29 = 0) sends length/4 buffer words, in address order, on the data handshake. `dat_blk_end` is high on every fourth word, which closes each 16-byte block.
- R6: A full data descriptor fetched before any key descriptor has completed since reset sets `err_order`, transfers nothing and parks the channel.
- R7: A full data descriptor whose byte length is not a multiple of 16 sets `err_len`, transfers nothing, writes nothing back and parks the channel. Both error flags clear when the channel is next enabled from idle.
- R8: After a buffer is consumed, word 1 of its descriptor is rewritten with bit 31 cleared and all other bits unchanged.
- R9: After each consumed descriptor the pointer moves on by two words, or returns to `ring_base` if the wrap flag (bit 30) was set.
- R10: A `ce_wr` pulse that arrives in the very cycle the channel decides to park is not lost. The channel fetches the parked descriptor again at once.
- R11: A presented word and its valid stay stable until ready is seen, and `key_valid` and `dat_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_base | input | AW | Word address of the first descriptor in the ring |
| ce_wr | input | 1 | Channel-enable write strobe, one cycle |
| chan_active | output | 1 | Enable bit read-back: 1 while working, 0 while parked |
| err_len | output | 1 | Data length was not a multiple of 16 bytes |
| err_order | output | 1 | Data descriptor arrived before any key |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (descriptor write-back) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after a read request |
| key_valid | output | 1 | Key word offered to the cipher |
| key_ready | input | 1 | Cipher accepts the key word |
| key_last | output | 1 | Final word of the key |
| dat_valid | output | 1 | Data word offered to the cipher |
| dat_ready | input | 1 | Cipher accepts the data word |
| dat_blk_end | output | 1 | Word closes a 16-byte block |
| xfer_word | output | 32 | Word being offered on either handshake |

## Verification
The decision to park on an empty descriptor and a software enable write can land in the same clock cycle. In that case the enable must restart the channel instead of being swallowed by the park.

The bench provokes this by watching the memory port for the read of a descriptor's control word. In the very next cycle, which is when the channel evaluates that word, the bench sets the full flag in memory and pulses `ce_wr`.

Two things judge the outcome. First, the control word must be read a second time. Second, the data that was armed late must be streamed in full. A channel that dropped the write would instead stay parked with nothing sent.

// File: rtl/crdma_pkg.sv
// Shared constants and state type for the descriptor ring channel.
// Assumes a 32-bit memory word and a two-word descriptor layout.
package crdma_pkg;

    localparam int WORD_W      = 32;
    localparam int DESC_F_BIT  = 31;   // full flag
    localparam int DESC_W_BIT  = 30;   // wrap to ring base
    localparam int DESC_K_BIT  = 29;   // 1 = key buffer, 0 = data buffer

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD0,
        S_RD1,
        S_CHK,
        S_BRD,
        S_BOUT,
        S_WB
    } chan_state_e;

endpackage

// File: rtl/crdma_desc_decode.sv
// Combinational decode of a descriptor control word.
// Assumes the caller hands over the field bits already sliced out.
module crdma_desc_decode #(
    parameter int LW = 16
) (
    input  logic          full_bit,
    input  logic          wrap_bit,
    input  logic          key_bit,
    input  logic [LW-1:0] byte_len,
    input  logic          key_loaded,
    output logic          full,
    output logic          wrap,
    output logic          is_key,
    output logic [LW-3:0] nwords,
    output logic          len_bad,
    output logic          order_bad
);

    // field extraction and legality checks
    always_comb begin
        full      = full_bit;
        wrap      = wrap_bit;
        is_key    = key_bit;
        nwords    = byte_len[LW-1:2];
        len_bad   = !key_bit && (byte_len[3:0] != 4'd0);
        order_bad = !key_bit && !key_loaded;
    end

endmodule

// File: rtl/crdma_ring_ptr.sv
// Descriptor fetch pointer: loads the ring base on reset and on wrap,
// otherwise steps by one two-word descriptor. Holds while parked.
module crdma_ring_ptr #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] base,
    input  logic          advance,
    input  logic          wrap,
    output logic [AW-1:0] ptr
);

    localparam logic [AW-1:0] DESC_STEP = AW'(2);

    // pointer register update
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= base;
        else if (advance)
            ptr <= wrap ? base : ptr + DESC_STEP;
    end

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !wrap) |=> (ptr == $past(ptr) + DESC_STEP)); // R9
    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && wrap) |=> (ptr == $past(base))); // R9
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(ptr)); // R3

endmodule

// File: rtl/crdma_xfer_cnt.sv
// Word index within the current buffer, with end-of-buffer and
// end-of-block flags. Assumes clr and inc are never high together.
module crdma_xfer_cnt #(
    parameter int NW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic [NW-1:0] nwords,
    output logic [NW-1:0] idx,
    output logic          done,
    output logic          last,
    output logic          blk_end
);

    localparam logic [NW-1:0] ONE = NW'(1);

    // index register
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= '0;
        else if (clr)
            idx <= '0;
        else if (inc)
            idx <= idx + ONE;
    end

    // position flags
    always_comb begin
        done    = (idx == nwords);
        last    = (idx == nwords - ONE);
        blk_end = &idx[1:0];
    end

    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> !done); // R5
    AST_CNT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr && inc)); // R4

endmodule

// File: rtl/crdma_chan.sv
// Descriptor ring channel feeding an ECB block cipher engine.
// Fetches two-word descriptors, streams key or data buffers, writes back
// the control word with the full flag cleared and parks on empty or bad
// descriptors until ce_wr. Assumes a memory with one-cycle read latency
// whose read data holds while no request is made.
module crdma_chan
    import crdma_pkg::*;
#(
    parameter int AW = 12,
    parameter int LW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     ring_base,
    input  logic              ce_wr,
    output logic              chan_active,
    output logic              err_len,
    output logic              err_order,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              key_valid,
    input  logic              key_ready,
    output logic              key_last,
    output logic              dat_valid,
    input  logic              dat_ready,
    output logic              dat_blk_end,
    output logic [WORD_W-1:0] xfer_word
);

    localparam int NW = LW - 2;

    chan_state_e       state_q, state_d;
    logic [AW-1:0]     ptr_q, buf_addr_q;
    logic [WORD_W-1:0] ctl_q, ctl_src, wb_word;
    logic              key_loaded_q, err_len_q, err_order_q;
    logic              dec_full, dec_wrap, dec_key, dec_len_bad, dec_order_bad;
    logic [NW-1:0]     dec_nwords, idx;
    logic              cnt_clr, cnt_inc, cnt_done, cnt_last, cnt_blk_end;
    logic              ptr_adv, park, xfer_ready, in_bout;

    // control word under inspection: live read data while checking, else stored copy
    always_comb begin
        ctl_src = (state_q == S_CHK) ? mem_rdata : ctl_q;
    end

    crdma_desc_decode #(.LW(LW)) u_dec (
        .full_bit   (ctl_src[DESC_F_BIT]),
        .wrap_bit   (ctl_src[DESC_W_BIT]),
        .key_bit    (ctl_src[DESC_K_BIT]),
        .byte_len   (ctl_src[LW-1:0]),
        .key_loaded (key_loaded_q),
        .full       (dec_full),
        .wrap       (dec_wrap),
        .is_key     (dec_key),
        .nwords     (dec_nwords),
        .len_bad    (dec_len_bad),
        .order_bad  (dec_order_bad)
    );

    crdma_ring_ptr #(.AW(AW)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .base    (ring_base),
        .advance (ptr_adv),
        .wrap    (dec_wrap),
        .ptr     (ptr_q)
    );

    crdma_xfer_cnt #(.NW(NW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .inc     (cnt_inc),
        .nwords  (dec_nwords),
        .idx     (idx),
        .done    (cnt_done),
        .last    (cnt_last),
        .blk_end (cnt_blk_end)
    );

    // handshake towards the cipher engine
    always_comb begin
        in_bout     = (state_q == S_BOUT);
        key_valid   = in_bout && dec_key;
        dat_valid   = in_bout && !dec_key;
        key_last    = key_valid && cnt_last;
        dat_blk_end = dat_valid && cnt_blk_end;
        xfer_word   = mem_rdata;
        xfer_ready  = dec_key ? key_ready : dat_ready;
    end

    // next-state logic and strobes
    always_comb begin
        state_d = state_q;
        park    = 1'b0;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        ptr_adv = 1'b0;
        case (state_q)
            S_IDLE: if (ce_wr) state_d = S_RD0;
            S_RD0:  state_d = S_RD1;
            S_RD1:  state_d = S_CHK;
            S_CHK: begin
                if (!dec_full || dec_order_bad || dec_len_bad) begin
                    park    = 1'b1;
                    state_d = ce_wr ? S_RD0 : S_IDLE;
                end else begin
                    cnt_clr = 1'b1;
                    state_d = S_BRD;
                end
            end
            S_BRD:  state_d = cnt_done ? S_WB : S_BOUT;
            S_BOUT: begin
                if (xfer_ready) begin
                    cnt_inc = 1'b1;
                    state_d = S_BRD;
                end
            end
            S_WB: begin
                ptr_adv = 1'b1;
                state_d = S_RD0;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // write-back word: stored control word with the full flag dropped
    always_comb begin
        wb_word             = ctl_q;
        wb_word[DESC_F_BIT] = 1'b0;
    end

    // memory port drive
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = wb_word;
        case (state_q)
            S_RD0: begin
                mem_req  = 1'b1;
                mem_addr = ptr_q;
            end
            S_RD1: begin
                mem_req  = 1'b1;
                mem_addr = ptr_q + AW'(1);
            end
            S_BRD: begin
                mem_req  = !cnt_done;
                mem_addr = buf_addr_q + AW'(idx);
            end
            S_WB: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = ptr_q + AW'(1);
            end
            default: ;
        endcase
    end

    // state, captured descriptor and sticky flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= S_IDLE;
            buf_addr_q   <= '0;
            ctl_q        <= '0;
            key_loaded_q <= 1'b0;
            err_len_q    <= 1'b0;
            err_order_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_RD1)
                buf_addr_q <= mem_rdata[AW-1:0];
            if (state_q == S_CHK)
                ctl_q <= mem_rdata;
            if (state_q == S_WB && dec_key)
                key_loaded_q <= 1'b1;
            if (state_q == S_IDLE && ce_wr) begin
                err_len_q   <= 1'b0;
                err_order_q <= 1'b0;
            end else if (state_q == S_CHK && dec_full) begin
                if (dec_order_bad)
                    err_order_q <= 1'b1;
                else if (dec_len_bad)
                    err_len_q <= 1'b1;
            end
        end
    end

    // status read-back
    always_comb begin
        chan_active = (state_q != S_IDLE);
        err_len     = err_len_q;
        err_order   = err_order_q;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_active |-> (!mem_req && !key_valid && !dat_valid)); // R2
    AST_PARK_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CHK && !dec_full && !ce_wr) |=> (!chan_active && !mem_req)); // R3
    AST_KEY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        dat_valid |-> key_loaded_q); // R6
    AST_LEN_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CHK && dec_full && !dec_order_bad && dec_len_bad && !ce_wr)
        |=> (err_len && !chan_active)); // R7
    AST_WB_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == ptr_q + AW'(1) && !mem_wdata[DESC_F_BIT])); // R8
    AST_CE_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (park && ce_wr) |=> (mem_req && !mem_we && mem_addr == ptr_q)); // R10
    AST_KEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && !key_ready) |=> (key_valid && $stable(xfer_word))); // R11
    AST_DAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_valid && !dat_ready) |=> (dat_valid && $stable(xfer_word))); // R11
    AST_ONE_SINK: assert property (@(posedge clk) disable iff (!rst_n)
        !(key_valid && dat_valid)); // R11

endmodule

// File: tb/crdma_chan_test.sv
// Self-checking bench for crdma_chan with a 256-word synchronous memory
// and irregular ready patterns on both cipher handshakes.
module crdma_chan_test;

    localparam int AW = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [AW-1:0] ring_base = '0;
    logic        ce_wr = 1'b0;
    logic        chan_active, err_len, err_order;
    logic        mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        key_valid, key_ready, key_last;
    logic        dat_valid, dat_ready, dat_blk_end;
    logic [31:0] xfer_word;

    logic [31:0] mem [0:255];
    logic [31:0] key_log [0:31];
    logic        key_lst [0:31];
    logic [31:0] dat_log [0:31];
    logic        dat_be  [0:31];
    int          rd_cnt  [0:15];
    int          key_n, dat_n;
    logic        clr = 1'b0;
    int          cyc = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;

    crdma_chan #(.AW(AW), .LW(16)) uut (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .ce_wr(ce_wr),
        .chan_active(chan_active), .err_len(err_len), .err_order(err_order),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .key_valid(key_valid), .key_ready(key_ready), .key_last(key_last),
        .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_blk_end(dat_blk_end),
        .xfer_word(xfer_word)
    );

    assign key_ready = (cyc % 3) != 0;
    assign dat_ready = (cyc % 5) != 2;

    // memory model, cycle counter and transfer logs
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req) begin
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[7:0]];
        end
        if (clr) begin
            key_n <= 0;
            dat_n <= 0;
            for (int i = 0; i < 16; i++) rd_cnt[i] <= 0;
        end else begin
            if (key_valid && key_ready && key_n < 32) begin
                key_log[key_n] <= xfer_word;
                key_lst[key_n] <= key_last;
                key_n <= key_n + 1;
            end
            if (dat_valid && dat_ready && dat_n < 32) begin
                dat_log[dat_n] <= xfer_word;
                dat_be[dat_n]  <= dat_blk_end;
                dat_n <= dat_n + 1;
            end
            if (mem_req && !mem_we && mem_addr < 16)
                rd_cnt[mem_addr] <= rd_cnt[mem_addr] + 1;
        end
    end

    function automatic logic [31:0] ctl(input bit f, input bit w, input bit k, input int len);
        return {f, w, k, 13'd0, len[15:0]};
    endfunction

    function automatic logic [31:0] pat(input int seed, input int i);
        return {seed[15:0], i[15:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_desc(input int addr, input int buf_a, input bit f, input bit w,
                            input bit k, input int len);
        mem[addr]   <= buf_a;
        mem[addr+1] <= ctl(f, w, k, len);
    endtask

    task automatic fill_buf(input int addr, input int n, input int seed);
        for (int i = 0; i < n; i++) mem[addr+i] <= pat(seed, i);
    endtask

    task automatic clear_logs();
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
    endtask

    task automatic do_reset(input int base);
        @(negedge clk);
        ring_base = AW'(base);
        rst_n = 1'b0;
        clr = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        clr = 1'b0;
    endtask

    task automatic pulse_ce();
        @(negedge clk) ce_wr = 1'b1;
        @(negedge clk) ce_wr = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        @(negedge clk);
        while (chan_active && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(req, 32'(chan_active), 32'd0);
    endtask

    task automatic check_dat(input string req, input int seed, input int n);
        check(req, 32'(dat_n), 32'(n));
        for (int i = 0; i < n; i++) begin
            check(req, dat_log[i], pat(seed, i));
            check(req, 32'(dat_be[i]), 32'((i % 4) == 3));
        end
    endtask

    task automatic check_key(input string req, input int seed, input int n);
        check(req, 32'(key_n), 32'(n));
        for (int i = 0; i < n; i++) begin
            check(req, key_log[i], pat(seed, i));
            check(req, 32'(key_lst[i]), 32'(i == n - 1));
        end
    endtask

    // watchdog
    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;

        // R1: reset state
        do_reset(0);
        @(negedge clk);
        check("R1 active", 32'(chan_active), 32'd0);
        check("R1 errors", {30'd0, err_len, err_order}, 32'd0);
        check("R1 quiet", {29'd0, mem_req, key_valid, dat_valid}, 32'd0);

        // R4 R5 R8 R3: key then data, parks on an empty third descriptor
        set_desc(0, 'h40, 1, 0, 1, 16);
        set_desc(2, 'h50, 1, 0, 0, 32);
        set_desc(4, 'h58, 0, 0, 0, 16);
        fill_buf('h40, 4, 1);
        fill_buf('h50, 8, 2);
        clear_logs();
        pulse_ce();
        check("R2 active", 32'(chan_active), 32'd1);
        wait_idle("R2 parked");
        check_key("R4", 1, 4);
        check_dat("R5", 2, 8);
        check("R8 key wb", mem[1], ctl(0, 0, 1, 16));
        check("R8 data wb", mem[3], ctl(0, 0, 0, 32));
        check("R3 untouched", mem[5], ctl(0, 0, 0, 16));
        check("R3 single fetch", 32'(rd_cnt[5]), 32'd1);
        check("R1 start at base", 32'(rd_cnt[0]), 32'd1);

        // R9 R3: arm the parked slot with wrap, channel resumes there, wraps, parks
        set_desc(4, 'h60, 1, 1, 0, 48);
        fill_buf('h60, 12, 3);
        clear_logs();
        pulse_ce();
        wait_idle("R9 parked");
        check_dat("R9 resumed", 3, 12);
        check("R9 no key", 32'(key_n), 32'd0);
        check("R9 wrapped", 32'(rd_cnt[1]), 32'd1);
        check("R9 no step past", 32'(rd_cnt[6]), 32'd0);
        check("R8 wrap kept", mem[5], ctl(0, 1, 0, 48));

        // R7: bad data length
        set_desc(0, 'h40, 1, 0, 0, 20);
        clear_logs();
        pulse_ce();
        wait_idle("R7 parked");
        check("R7 flag", 32'(err_len), 32'd1);
        check("R7 no data", 32'(dat_n), 32'd0);
        check("R7 no wb", mem[1], ctl(1, 0, 0, 20));
        set_desc(0, 'h40, 1, 0, 0, 16);
        clear_logs();
        pulse_ce();
        wait_idle("R7 retry");
        check("R7 cleared", 32'(err_len), 32'd0);
        check_dat("R7 retry data", 1, 4);

        // R6: data before key after a fresh reset
        do_reset(0);
        set_desc(0, 'h40, 1, 0, 0, 16);
        clear_logs();
        pulse_ce();
        wait_idle("R6 parked");
        check("R6 flag", 32'(err_order), 32'd1);
        check("R6 no data", 32'(dat_n), 32'd0);
        check("R6 no wb", mem[1], ctl(1, 0, 0, 16));

        // R10: enable write lands in the park-decision cycle
        do_reset(0);
        set_desc(0, 'h40, 1, 0, 1, 32);
        set_desc(2, 'h50, 0, 0, 0, 16);
        set_desc(4, 'h58, 0, 0, 0, 16);
        fill_buf('h40, 8, 4);
        fill_buf('h50, 4, 5);
        clear_logs();
        pulse_ce();
        begin
            int g = 0;
            while (!(mem_req && !mem_we && mem_addr == 3) && g < 5000) begin
                @(negedge clk);
                g++;
            end
        end
        @(posedge clk);
        @(negedge clk);
        mem[3] <= ctl(1, 0, 0, 16);
        ce_wr = 1'b1;
        @(negedge clk);
        ce_wr = 1'b0;
        wait_idle("R10 parked");
        check("R10 refetch", 32'(rd_cnt[3]), 32'd2);
        check_dat("R10 data", 5, 4);
        check_key("R4 eight words", 4, 8);
        check("R10 wb", mem[3], ctl(0, 0, 0, 16));

        // R5 R7 R1: sweep data length 0..64 bytes on a non-zero ring base
        for (int len = 0; len <= 64; len += 4) begin
            do_reset(8);
            set_desc(8, 'h40, 1, 0, 1, 16);
            set_desc(10, 'h80, 1, 0, 0, len);
            set_desc(12, 'h90, 0, 0, 0, 16);
            fill_buf('h40, 4, 'h77);
            fill_buf('h80, 16, len);
            pulse_ce();
            wait_idle("R2 sweep");
            check("R1 base fetch", 32'(rd_cnt[8]), 32'd1);
            check_key("R4 sweep", 'h77, 4);
            if (len % 16 == 0) begin
                check("R7 sweep ok", 32'(err_len), 32'd0);
                check_dat("R5 sweep", len, len / 4);
                check("R8 sweep", mem[11], ctl(0, 0, 0, len));
            end else begin
                check("R7 sweep flag", 32'(err_len), 32'd1);
                check("R7 sweep none", 32'(dat_n), 32'd0);
                check("R7 sweep no wb", mem[11], ctl(1, 0, 0, len));
            end
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule